// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the device side of a word-wide parallel NOR flash. It sits behind three active-low strobes (chip select, write strobe, read strobe), an address bus and a bidirectional 16-bit data bus. It keeps the word array, drives that array onto the bus during reads, and turns write cycles into program and erase operations. The strobes are asynchronous. The block samples them on its own clock. The host is assumed to hold each strobe level for at least two clocks.

Any change to the array has to be unlocked first. Before the program word, a program takes three unlock cycles. A sector or block erase takes five setup cycles before its command cycle. Once an operation starts, the block is busy for a number of clocks set by a parameter. While busy it ignores all writes, and reads return a polling word: one bit toggles on each read, and a second bit reports the inverse of the programmed bit 7, or zero during an erase. When the operation ends, reads return array contents again. The default geometry is small (2K words, 128-word sectors, 512-word blocks) so that it can be elaborated and checked. The full-size geometry (19 address bits, 2K-word sectors, 32K-word blocks) comes from parameters alone.

Top module: `flash_nor_ctrl`

## Requirements
- R1: The target address of a write cycle is taken when the second of chip select and write strobe goes low. The data is taken from the bus as it was just before the first of the two goes high. Changes on the bus after that edge, or changes on the address after the later falling edge, do not alter the operation.
- R2: The data bus is driven only while chip select and read strobe are both low. In every other case it is high impedance.
- R3: A program starts only after this exact sequence: address = low ADDR_W bits of 5555h with data AAh, then the low bits of 2AAAh with 55h, then 5555h with A0h, and then a fourth cycle carrying the target address and the word. Only the low 8 data bits are compared.
- R4: A program stores the bitwise AND of the old word and the written word, so it can only clear bits.
- R5: Sector erase uses the unlock pair, then 5555h/80h, then the unlock pair again, then a sixth cycle with data 30h. It sets every word of the 2^SECT_AW-word aligned sector that holds the sixth cycle's address to FFFFh. Words outside that sector keep their contents.
- R6: Block erase uses the same five setup cycles with 50h in the sixth cycle. It sets every word of the 2^BLK_AW-word aligned block to FFFFh.
- R7: A cycle whose address or data does not match the expected value, including an unknown erase command, returns the sequencer to idle and starts nothing.
- R8: While an operation runs, every write cycle is ignored, including complete program sequences, and the sequencer is idle when the operation ends.
- R9: A program keeps the block busy for PROG_CYC clocks. An erase keeps it busy for the larger of ERASE_CYC clocks and one clock more than the erased region size. After that, reads return array data.
- R10: While busy, a read returns a status word. Bit 7 is the inverse of bit 7 of the programmed word during a program, and 0 during an erase. Bit 6 changes on each new read. All other bits are 0.
- R11: After reset the block is idle and not busy, and the data bus is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Word address |
| dq | inout | DATA_W | Bidirectional data bus |

## Verification
The strobes pass through one sampling register. The bus output enable therefore follows chip select and read strobe after one clock edge, and read data or a status word is valid after two edges. The bench holds each read for three clocks and samples on the falling clock edge, after that point. An operation begins three edges after the strobe rise that ends its last cycle. Status reads are placed inside the busy window, with a margin of several clocks on both sides of PROG_CYC and ERASE_CYC. Array reads come only after the full busy time plus a margin. The toggle bit is judged by comparing two reads, never against a fixed absolute value.

// File: rtl/flash_nor_pkg.sv
// Shared types and command constants for the NOR flash command block.
// Assumes unlock addresses are compared on the low ADDR_W bits only.
package flash_nor_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM,
        SQ_ESET,
        SQ_EUNL1,
        SQ_EUNL2
    } seq_state_e;

    typedef enum logic [1:0] {
        OPK_PROG,
        OPK_SECT,
        OPK_BLK
    } op_kind_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A         = 8'hAA;
    localparam logic [7:0]  KEY_B         = 8'h55;
    localparam logic [7:0]  CMD_PROG      = 8'hA0;
    localparam logic [7:0]  CMD_ESETUP    = 8'h80;
    localparam logic [7:0]  CMD_SECT      = 8'h30;
    localparam logic [7:0]  CMD_BLK       = 8'h50;

endpackage

// File: rtl/flash_bus_capture.sv
// Samples the asynchronous bus strobes and turns them into cycle events.
// A write cycle is active while chip select and write strobe are both low.
// The address is held at the later falling edge. The data is the bus value
// seen while the cycle was still active. Assumes strobes stay stable >= 2 clocks.
module flash_bus_capture #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data,
    output logic              wr_done,
    output logic              rd_start,
    output logic              drive_en,
    output logic [ADDR_W-1:0] rd_addr
);

    logic              ce_q, we_q, oe_q;
    logic              wr_act, wr_act_d, rd_act_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_hold;

    assign wr_act   = !ce_q && !we_q;
    assign drive_en = !ce_q && !oe_q;
    assign wr_done  = !wr_act && wr_act_d;
    assign rd_start = drive_en && !rd_act_d;
    assign rd_addr  = addr_q;
    assign cyc_data = data_hold;

    // Sample the pins and keep one cycle of strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q      <= 1'b1;
            we_q      <= 1'b1;
            oe_q      <= 1'b1;
            addr_q    <= '0;
            wr_act_d  <= 1'b0;
            rd_act_d  <= 1'b0;
            data_hold <= '0;
            cyc_addr  <= '0;
        end else begin
            ce_q     <= ce_n;
            we_q     <= we_n;
            oe_q     <= oe_n;
            addr_q   <= addr;
            wr_act_d <= wr_act;
            rd_act_d <= drive_en;
            if (!ce_n && !we_n) begin
                data_hold <= dq_in;
            end
            if (wr_act && !wr_act_d) begin
                cyc_addr <= addr_q;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Command sequencer. Each completed write cycle moves it through the unlock
// and setup steps. It emits a one-clock start pulse with the operation kind,
// address and data. Assumes the busy input covers the whole operation.
module flash_cmd_seq
    import flash_nor_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              busy,
    output logic              start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    localparam logic [ADDR_W-1:0] UA_A = ADDR_W'(UNLOCK_ADDR_A);
    localparam logic [ADDR_W-1:0] UA_B = ADDR_W'(UNLOCK_ADDR_B);

    seq_state_e state;
    logic       hit_a, hit_b;
    logic [7:0] code;

    assign code  = cyc_data[7:0];
    assign hit_a = (cyc_addr == UA_A) && (code == KEY_A);
    assign hit_b = (cyc_addr == UA_B) && (code == KEY_B);

    // Advance the unlock/setup sequence on each completed write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            start   <= 1'b0;
            op_kind <= OPK_PROG;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            start <= 1'b0;
            if (busy) begin
                state <= SQ_IDLE;
            end else if (wr_done) begin
                state <= SQ_IDLE;
                case (state)
                    SQ_IDLE:  if (hit_a) state <= SQ_UNL1;
                    SQ_UNL1:  if (hit_b) state <= SQ_UNL2;
                    SQ_UNL2: begin
                        if (cyc_addr == UA_A && code == CMD_PROG)   state <= SQ_PGM;
                        if (cyc_addr == UA_A && code == CMD_ESETUP) state <= SQ_ESET;
                    end
                    SQ_PGM: begin
                        start   <= 1'b1;
                        op_kind <= OPK_PROG;
                        op_addr <= cyc_addr;
                        op_data <= cyc_data;
                    end
                    SQ_ESET:  if (hit_a) state <= SQ_EUNL1;
                    SQ_EUNL1: if (hit_b) state <= SQ_EUNL2;
                    SQ_EUNL2: begin
                        if (code == CMD_SECT || code == CMD_BLK) begin
                            start   <= 1'b1;
                            op_kind <= (code == CMD_SECT) ? OPK_SECT : OPK_BLK;
                            op_addr <= cyc_addr;
                        end
                    end
                    default:  state <= SQ_IDLE;
                endcase
            end
        end
    end

    // The sequencer must rest in idle for the whole busy phase.
    assert_idle_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == SQ_IDLE));

    // No operation may be launched while another one runs.
    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/flash_op_engine.sv
// Owns the word array, the busy timer, the erase walker and the read word.
// A program is a read-modify-write AND applied at start. An erase writes
// all-ones over the region, one word per clock. Busy ends when the timer
// has expired and the walk is finished. Assumes DATA_W >= 8, ADDR_W >= BLK_AW.
module flash_op_engine
    import flash_nor_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 16,
    parameter int SECT_AW   = 7,
    parameter int BLK_AW    = 9,
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_e          op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_start,
    output logic              busy,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int LONG_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int WALK_CYC = (1 << BLK_AW) + 1;
    localparam int BUSY_MAX = ((LONG_CYC > WALK_CYC) ? LONG_CYC : WALK_CYC) + 1;
    localparam int TMR_W    = $clog2(LONG_CYC + 1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_AW) - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((1 << BLK_AW) - 1);
    localparam logic [BLK_AW-1:0] SECT_LAST = BLK_AW'((1 << SECT_AW) - 1);
    localparam logic [BLK_AW-1:0] BLK_LAST  = '1;

    logic [DATA_W-1:0] mem [0:DEPTH-1];
    logic [DATA_W-1:0] rd_q;
    logic [TMR_W-1:0]  timer;
    logic              walk_on;
    logic [BLK_AW-1:0] walk_idx, walk_last;
    logic [ADDR_W-1:0] base_q;
    logic              is_prog_q, inv7_q, tog_q;
    logic [DATA_W-1:0] status;
    int unsigned       busy_run;

    // Polling word: bit 7 inverse program bit or zero, bit 6 toggle, rest zero.
    always_comb begin
        status    = '0;
        status[7] = is_prog_q ? inv7_q : 1'b0;
        status[6] = tog_q;
    end

    assign rd_word = busy ? status : rd_q;

    // Single write port for program and erase, plus the registered read port.
    always_ff @(posedge clk) begin
        if (start && op_kind == OPK_PROG) begin
            mem[op_addr] <= mem[op_addr] & op_data;
        end else if (walk_on) begin
            mem[base_q | ADDR_W'(walk_idx)] <= '1;
        end
        rd_q <= mem[rd_addr];
    end

    // Busy timer and erase walker control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            timer     <= '0;
            walk_on   <= 1'b0;
            walk_idx  <= '0;
            walk_last <= '0;
            base_q    <= '0;
            is_prog_q <= 1'b0;
            inv7_q    <= 1'b0;
        end else if (start) begin
            busy      <= 1'b1;
            is_prog_q <= (op_kind == OPK_PROG);
            inv7_q    <= ~op_data[7];
            walk_idx  <= '0;
            if (op_kind == OPK_PROG) begin
                timer   <= TMR_W'(PROG_CYC - 1);
                walk_on <= 1'b0;
            end else begin
                timer     <= TMR_W'(ERASE_CYC - 1);
                walk_on   <= 1'b1;
                walk_last <= (op_kind == OPK_SECT) ? SECT_LAST : BLK_LAST;
                base_q    <= op_addr & ~((op_kind == OPK_SECT) ? SECT_MASK : BLK_MASK);
            end
        end else if (busy) begin
            if (timer != '0) timer <= timer - 1'b1;
            if (walk_on) begin
                if (walk_idx == walk_last) walk_on <= 1'b0;
                else walk_idx <= walk_idx + 1'b1;
            end
            if (timer == '0 && !walk_on) busy <= 1'b0;
        end
    end

    // Toggle bit flips on every new read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else if (busy && rd_start) tog_q <= ~tog_q;
    end

    // Independent count of busy length for the bounded-time check.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else busy_run <= 0;
    end

    assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= BUSY_MAX);

    assert_walk_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_on |-> busy);

    assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/flash_nor_ctrl.sv
// Top of the NOR flash command block. It joins bus capture, command sequencer
// and operation engine, and drives the tri-state data bus.
// Assumes the strobes are held >= 2 clocks.
module flash_nor_ctrl
    import flash_nor_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 16,
    parameter int SECT_AW   = 7,
    parameter int BLK_AW    = 9,
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] dq
);

    logic [ADDR_W-1:0] cyc_addr, rd_addr, op_addr;
    logic [DATA_W-1:0] cyc_data, op_data, rd_word;
    logic              wr_done, rd_start, drive_en, start, busy;
    op_kind_e          op_kind;

    assign dq = drive_en ? rd_word : {DATA_W{1'bz}};

    flash_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
        .wr_done(wr_done), .rd_start(rd_start), .drive_en(drive_en),
        .rd_addr(rd_addr)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .cyc_addr(cyc_addr),
        .cyc_data(cyc_data), .busy(busy), .start(start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data)
    );

    flash_op_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) eng_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .rd_addr(rd_addr),
        .rd_start(rd_start), .busy(busy), .rd_word(rd_word)
    );

    // Output enable may only follow a sampled select plus read strobe.
    assert_drive_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ($past(ce_n) == 1'b0 && $past(oe_n) == 1'b0));

endmodule

// File: tb/flash_nor_ctrl_tb.sv
// Directed bench for the NOR flash command block, one task per scenario.
module flash_nor_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int PROG_CYC   = 40;
    localparam int ERASE_CYC  = 600;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       drv = '0;
    logic              den = 1'b0;
    wire  [15:0]       dq;
    int                checks = 0;
    int                errors = 0;

    assign dq = den ? drv : 16'hzzzz;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_nor_ctrl #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq(dq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; drv = d; den = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; den = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        v = dq;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic unlock_prog();
        bus_write(11'h555, 16'h00AA);
        bus_write(11'h2AA, 16'h0055);
        bus_write(11'h555, 16'h00A0);
    endtask

    task automatic program_word(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        unlock_prog();
        bus_write(a, d);
    endtask

    task automatic erase_cmd(input logic [ADDR_W-1:0] a, input logic [7:0] cmd);
        bus_write(11'h555, 16'h00AA);
        bus_write(11'h2AA, 16'h0055);
        bus_write(11'h555, 16'h0080);
        bus_write(11'h555, 16'h00AA);
        bus_write(11'h2AA, 16'h0055);
        bus_write(a, {8'h00, cmd});
    endtask

    task automatic settle_prog();
        repeat (PROG_CYC + 10) @(negedge clk);
    endtask

    task automatic settle_erase();
        repeat (ERASE_CYC + 20) @(negedge clk);
    endtask

    // R11, R2: idle bus after reset, and no drive without both strobes low.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R11 bus idle after reset", dq, 16'hzzzz);
        ce_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 select without read strobe", dq, 16'hzzzz);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 read strobe without select", dq, 16'hzzzz);
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // R6, R8, R10: block erase of block 0, with a program attempt while busy.
    task automatic t_block_erase();
        logic [15:0] s1, s2, v;
        erase_cmd(11'h005, 8'h50);
        bus_read(11'h000, s1);
        bus_read(11'h000, s2);
        check("R10 erase status other bits", s1 & 16'hFFBF, 16'h0000);
        check("R10 toggle differs", {15'd0, s1[6] ^ s2[6]}, 16'h0001);
        program_word(11'h010, 16'h0000);
        settle_erase();
        bus_read(11'h000, v); check("R6 block first word", v, 16'hFFFF);
        bus_read(11'h1FF, v); check("R6 block last word", v, 16'hFFFF);
        bus_read(11'h010, v); check("R8 write during busy ignored", v, 16'hFFFF);
    endtask

    // R3, R4, R9, R10: program, status window, then AND behaviour.
    task automatic t_program();
        logic [15:0] s1, s2, v;
        program_word(11'h020, 16'h1275);
        bus_read(11'h020, s1);
        bus_read(11'h020, s2);
        check("R10 program status bit7 inverse", s1 & 16'hFFBF, 16'h0080);
        check("R10 program toggle differs", {15'd0, s1[6] ^ s2[6]}, 16'h0001);
        settle_prog();
        bus_read(11'h020, v); check("R9 R3 data after program", v, 16'h1275);
        program_word(11'h020, 16'hFF0F);
        settle_prog();
        bus_read(11'h020, v); check("R4 program ANDs old word", v, 16'h1205);
        program_word(11'h010, 16'h00FF);
        settle_prog();
        bus_read(11'h010, v); check("R8 sequencer idle after busy", v, 16'h00FF);
    endtask

    // R7: wrong data and wrong address abort the sequence, then recovery.
    task automatic t_abort();
        logic [15:0] v;
        bus_write(11'h555, 16'h00AA);
        bus_write(11'h2AA, 16'h0056);
        bus_write(11'h555, 16'h00A0);
        bus_write(11'h030, 16'h0000);
        settle_prog();
        bus_read(11'h030, v); check("R7 bad key data aborts", v, 16'hFFFF);
        bus_write(11'h555, 16'h00AA);
        bus_write(11'h2AB, 16'h0055);
        bus_write(11'h555, 16'h00A0);
        bus_write(11'h031, 16'h0000);
        settle_prog();
        bus_read(11'h031, v); check("R7 bad key address aborts", v, 16'hFFFF);
        program_word(11'h030, 16'h00FF);
        settle_prog();
        bus_read(11'h030, v); check("R7 valid sequence after abort", v, 16'h00FF);
        erase_cmd(11'h030, 8'h10);
        bus_read(11'h030, v); check("R7 unknown erase command ignored", v, 16'h00FF);
    endtask

    // R1: address at the later falling edge, data at the earlier rising edge.
    task automatic t_edge_order();
        logic [15:0] v;
        unlock_prog();
        @(negedge clk);
        ce_n = 1'b0; addr = 11'h040; drv = 16'h3333; den = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 11'h041;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        drv = 16'h0000;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; den = 1'b0;
        settle_prog();
        bus_read(11'h040, v); check("R1 write-strobe-last address", v, 16'h3333);
        bus_read(11'h041, v); check("R1 later address ignored", v, 16'hFFFF);
        unlock_prog();
        @(negedge clk);
        we_n = 1'b0; addr = 11'h051;
        repeat (2) @(negedge clk);
        addr = 11'h050; ce_n = 1'b0; drv = 16'h4444; den = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        drv = 16'h0000;
        repeat (2) @(negedge clk);
        we_n = 1'b1; den = 1'b0;
        settle_prog();
        bus_read(11'h050, v); check("R1 select-last address and early data", v, 16'h4444);
        bus_read(11'h051, v); check("R1 address before select ignored", v, 16'hFFFF);
    endtask

    // R5: sector erase clears one aligned sector only.
    task automatic t_sector();
        logic [15:0] s1, v;
        program_word(11'h0A0, 16'h0000); settle_prog();
        program_word(11'h100, 16'h0000); settle_prog();
        program_word(11'h07F, 16'h0000); settle_prog();
        erase_cmd(11'h0C5, 8'h30);
        bus_read(11'h0A0, s1);
        check("R10 sector erase status bit7 zero", {15'd0, s1[7]}, 16'h0000);
        settle_erase();
        bus_read(11'h080, v); check("R5 sector first word", v, 16'hFFFF);
        bus_read(11'h0A0, v); check("R5 sector programmed word", v, 16'hFFFF);
        bus_read(11'h0FF, v); check("R5 sector last word", v, 16'hFFFF);
        bus_read(11'h100, v); check("R5 next sector untouched", v, 16'h0000);
        bus_read(11'h07F, v); check("R5 previous sector untouched", v, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_block_erase();
        t_program();
        t_abort();
        t_edge_order();
        t_sector();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule